// File: doc/BRIEF.md
# Single-Cycle ALU Instruction Core

This block is a processor core that completes one arithmetic or logic instruction on every rising clock edge. It presents its program counter as a combinational instruction address, receives the 32-bit instruction word back in the same cycle, and decodes the 6-bit opcode through a 64-entry control lookup. The lookup yields the ALU function, a register-file write enable and the select for the second operand.

Operands are read from a 32-entry register file. The first operand is always the register named by the first source field. The second is either the register named by the second source field or a 16-bit literal from the instruction, widened to 32 bits by copying its sign bit. The ALU result goes back to the destination register, and the PC advances by 4, both on the same rising edge.

Opcodes outside the ALU groups write nothing and only advance the PC. The register write port is visible at the block's edge, so the surrounding system can observe what each instruction commits.

Top module: `sc_alu_core`

## Requirements
- R1: Opcode bits [31:26] select the behaviour. Opcode 0x20+f performs a register-register operation and opcode 0x30+f a register-literal operation, each with ALU function f for f in 0..9. Every other opcode is a no-op.
- R2: While rst_ni is low, imem_addr_o is 0x00000000, wb_en_o is 0, and all registers are cleared to zero.
- R3: The destination index is bits [25:21], the first source index is bits [20:16], and the second source index is bits [15:11]. wb_addr_o carries the destination index.
- R4: Out of reset, imem_addr_o is 0 in the first cycle and rises by exactly 4 on every rising edge.
- R5: The function codes are 0 add, 1 subtract (a-b), 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right and 7 arithmetic shift right. All shifts take their amount from bits [4:0] of the second operand.
- R6: Function 8 (equal) and function 9 (signed less-than) produce 1 or 0 in bit 0, with all other bits zero.
- R7: In the literal group, the second operand is bits [15:0] with bit 15 copied into bits [31:16].
- R8: A no-op opcode leaves wb_en_o at 0 and changes no register.
- R9: Register 31 always reads as zero. A write to index 31 is discarded and wb_en_o stays 0.
- R10: A register write takes effect at the rising edge. An instruction that reads the register it writes uses the old value, and the next instruction sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state commits on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Instruction address (current PC) |
| imem_data_i | input | 32 | Instruction word for imem_addr_o |
| wb_en_o | output | 1 | A register write commits at the next rising edge |
| wb_addr_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Value being written |

## Verification
Two things can happen in the same cycle: an instruction reads a register, and the same register is being written. To provoke this, the program doubles a register into itself. The bench expects the result to be built from the old value, and it expects the following instruction, which copies that register through the zero register, to return the doubled value. The program also writes to index 31 and then reads index 31 back, and it runs no-op opcodes whose destination field names a live register. In both cases the bench expects no write and an unchanged value when the register is read later.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned OP_W = 6;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned CTRL_DEPTH = 1 << OP_W;

  typedef enum logic [3:0] {
    FN_ADD = 4'd0, FN_SUB = 4'd1, FN_AND = 4'd2, FN_OR  = 4'd3, FN_XOR = 4'd4,
    FN_SHL = 4'd5, FN_SHR = 4'd6, FN_SRA = 4'd7, FN_CEQ = 4'd8, FN_CLT = 4'd9
  } alufn_e;

  typedef struct packed {
    alufn_e fn;
    logic   werf;
    logic   bsel;
  } ctrl_t;

  // 0x20+f register form, 0x30+f literal form; everything else writes nothing
  function automatic ctrl_t decode_op(input logic [OP_W-1:0] op);
    ctrl_t c;
    c.fn   = FN_ADD;
    c.werf = 1'b0;
    c.bsel = 1'b0;
    if (op[5] && op[3:0] <= 4'd9) begin
      c.fn   = alufn_e'(op[3:0]);
      c.werf = 1'b1;
      c.bsel = op[4];
    end
    return c;
  endfunction
endpackage

// File: rtl/dp_ctrl_rom.sv
module dp_ctrl_rom
  import dp_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  ctrl_t rom [CTRL_DEPTH];

  for (genvar g = 0; g < CTRL_DEPTH; g++) begin : g_rom
    assign rom[g] = decode_op(OP_W'(g));
  end

  assign ctrl_o = rom[op_i];

  always_comb begin
    if (ctrl_o.bsel) p_bsel_lit_group_r1: assert (op_i[5:4] == 2'b11);
    if (ctrl_o.werf) p_werf_alu_only_r8: assert (op_i[5] == 1'b1);
  end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int unsigned NREG = (1 << IDX_W) - 1;  // top index is hard zero
  localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(NREG);

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[g] <= '0;
      else if (we_i && wr_addr_i == IDX_W'(g)) regs_q[g] <= wr_data_i;
    end
  end

  assign ra_data_o = (ra_addr_i == ZERO_IDX) ? '0 : regs_q[ra_addr_i];
  assign rb_data_o = (rb_addr_i == ZERO_IDX) ? '0 : regs_q[rb_addr_i];

  always_comb begin
    if (ra_addr_i == ZERO_IDX) p_zero_reg_a_r9: assert (ra_data_o == '0);
    if (rb_addr_i == ZERO_IDX) p_zero_reg_b_r9: assert (rb_data_o == '0);
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alufn_e            fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] sh;
  assign sh = b_i[SH_W-1:0];

  always_comb begin
    unique case (fn_i)
      FN_ADD:  y_o = a_i + b_i;
      FN_SUB:  y_o = a_i - b_i;
      FN_AND:  y_o = a_i & b_i;
      FN_OR:   y_o = a_i | b_i;
      FN_XOR:  y_o = a_i ^ b_i;
      FN_SHL:  y_o = a_i << sh;
      FN_SHR:  y_o = a_i >> sh;
      FN_SRA:  y_o = $unsigned($signed(a_i) >>> sh);
      FN_CEQ:  y_o = DATA_W'(a_i == b_i);
      FN_CLT:  y_o = DATA_W'($signed(a_i) < $signed(b_i));
      default: y_o = '0;
    endcase
  end

  always_comb begin
    if (fn_i == FN_CEQ || fn_i == FN_CLT)
      p_cmp_boolean_r6: assert (y_o[DATA_W-1:1] == '0);
  end
endmodule

// File: rtl/sc_alu_core.sv
module sc_alu_core
  import dp_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] imem_addr_o,
  input  logic [31:0] imem_data_i,
  output logic        wb_en_o,
  output logic [4:0]  wb_addr_o,
  output logic [31:0] wb_data_o
);
  localparam logic [RIDX_W-1:0] ZERO_IDX = '1;
  localparam int unsigned LIT_W = 16;

  logic [XLEN-1:0]   pc_q, pc_plus4;
  logic [OP_W-1:0]   op;
  logic [RIDX_W-1:0] rc, ra, rb;
  logic [XLEN-1:0]   lit_sx, ra_data, rb_data, opb, alu_y;
  ctrl_t             ctrl;

  assign op     = imem_data_i[31:26];
  assign rc     = imem_data_i[25:21];
  assign ra     = imem_data_i[20:16];
  assign rb     = imem_data_i[15:11];
  assign lit_sx = {{(XLEN-LIT_W){imem_data_i[LIT_W-1]}}, imem_data_i[LIT_W-1:0]};

  assign pc_plus4 = pc_q + 32'd4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_plus4;
  end

  dp_ctrl_rom u_ctrl (
    .op_i   (op),
    .ctrl_o (ctrl)
  );

  dp_regfile #(.DATA_W(XLEN), .IDX_W(RIDX_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_addr_i (ra),
    .ra_data_o (ra_data),
    .rb_addr_i (rb),
    .rb_data_o (rb_data),
    .we_i      (wb_en_o),
    .wr_addr_i (rc),
    .wr_data_i (alu_y)
  );

  assign opb = ctrl.bsel ? lit_sx : rb_data;

  dp_alu #(.DATA_W(XLEN)) u_alu (
    .fn_i (ctrl.fn),
    .a_i  (ra_data),
    .b_i  (opb),
    .y_o  (alu_y)
  );

  // write gated by reset and by the hard-zero index
  assign wb_en_o     = ctrl.werf && rst_ni && (rc != ZERO_IDX);
  assign wb_addr_o   = rc;
  assign wb_data_o   = alu_y;
  assign imem_addr_o = pc_q;

  p_pc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pc_q == $past(pc_q) + 32'd4);

  p_nonalu_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op[5] && op[3:0] <= 4'd9) |-> !wb_en_o);

  p_zero_idx_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rc == ZERO_IDX) |-> !wb_en_o);

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_state_r2: assert (pc_q == RESET_PC && !wb_en_o);
  end
endmodule

// File: tb/sc_alu_core_tb_top.sv
module sc_alu_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] imem_addr, imem_data;
  logic        wb_en;
  logic [4:0]  wb_addr;
  logic [31:0] wb_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sc_alu_core dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .imem_addr_o (imem_addr),
    .imem_data_i (imem_data),
    .wb_en_o     (wb_en),
    .wb_addr_o   (wb_addr),
    .wb_data_o   (wb_data)
  );

  function automatic logic [31:0] rr(input int fn, input int rc, input int ra, input int rb);
    return {6'(32'h20 + fn), 5'(rc), 5'(ra), 5'(rb), 11'd0};
  endfunction
  function automatic logic [31:0] rl(input int fn, input int rc, input int ra, input logic [15:0] lit);
    return {6'(32'h30 + fn), 5'(rc), 5'(ra), lit};
  endfunction
  function automatic logic [69:0] v(input logic [31:0] ins, input logic en, input int rc, input logic [31:0] d);
    return {ins, en, 5'(rc), d};
  endfunction

  localparam int N = 23;
  // {instruction, expected wb_en, expected wb_addr, expected wb_data}
  localparam logic [69:0] VEC [N] = '{
    v(rl(0, 1, 31, 16'd5),     1, 1,  32'd5),         // R7 R1 addc
    v(rl(0, 2, 31, 16'hFFFD),  1, 2,  32'hFFFF_FFFD), // R7 sign extension
    v(rr(0, 3, 1, 2),          1, 3,  32'd2),         // R5 add
    v(rr(1, 4, 1, 2),          1, 4,  32'd8),         // R5 sub
    v(rr(2, 5, 1, 2),          1, 5,  32'd5),         // R5 and
    v(rr(3, 6, 1, 2),          1, 6,  32'hFFFF_FFFD), // R5 or
    v(rr(4, 7, 1, 2),          1, 7,  32'hFFFF_FFF8), // R5 xor
    v(rl(5, 8, 1, 16'd4),      1, 8,  32'h50),        // R5 shl literal
    v(rr(6, 9, 2, 1),          1, 9,  32'h07FF_FFFF), // R5 shr
    v(rr(7, 10, 2, 1),         1, 10, 32'hFFFF_FFFF), // R5 sra
    v(rr(9, 11, 2, 1),         1, 11, 32'd1),         // R6 signed lt
    v(rr(8, 12, 1, 1),         1, 12, 32'd1),         // R6 eq
    v(rl(8, 13, 1, 16'd6),     1, 13, 32'd0),         // R6 eq literal false
    v(rr(0, 31, 1, 1),         0, 31, 32'd0),         // R9 write to 31 discarded
    v(rr(0, 14, 31, 31),       1, 14, 32'd0),         // R9 31 reads zero
    v({6'h01, 5'd1, 5'd1, 16'd0}, 0, 1, 32'd0),       // R8 no-op
    v(rr(0, 15, 1, 31),        1, 15, 32'd5),         // R8 r1 kept
    v({6'h2A, 5'd1, 5'd1, 16'd0}, 0, 1, 32'd0),       // R8 unused code in group
    v(rl(9, 16, 1, 16'hFFFF),  1, 16, 32'd0),         // R6 R7 5 < -1 false
    v(rr(0, 17, 3, 4),         1, 17, 32'd10),        // R3 field positions
    v(rl(2, 18, 2, 16'h7FFF),  1, 18, 32'h0000_7FFD), // R7 positive literal
    v(rr(0, 1, 1, 1),          1, 1,  32'd10),        // R10 read-old
    v(rr(0, 19, 1, 31),        1, 19, 32'd10)         // R10 new value seen
  };

  always_comb begin
    if (imem_addr[31:2] < 30'(N)) imem_data = VEC[imem_addr[31:2]][69:38];
    else                          imem_data = 32'h0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 pc in reset", imem_addr, 32'h0);
    chk("R2 no write in reset", 32'(wb_en), 32'h0);
    rst_ni = 1'b1;
    #1;
    for (int k = 0; k < N; k++) begin
      chk("R4 pc", imem_addr, 32'(4 * k));
      chk("R1 R8 R9 wb_en", 32'(wb_en), 32'(VEC[k][37]));
      if (VEC[k][37]) begin
        chk("R3 wb_addr", 32'(wb_addr), 32'(VEC[k][36:32]));
        chk("R5 R6 R7 R10 wb_data", wb_data, VEC[k][31:0]);
      end
      @(negedge clk);
      #1;
    end
    // mid-run reset: ALU instruction present, yet no write and registers cleared
    rst_ni = 1'b0;
    #1;
    chk("R2 pc cleared", imem_addr, 32'h0);
    chk("R2 write held off", 32'(wb_en), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    @(negedge clk);
    @(negedge clk);
    #1;
    // pc=8: add r3 = r1 + r2, registers rebuilt from cleared state by instrs 0,1
    chk("R4 pc after reset", imem_addr, 32'd8);
    chk("R2 regs rebuilt", wb_data, 32'd2);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    #1;
    // pc=20: or r6 = r1 | r2
    chk("R5 or after reset", wb_data, 32'hFFFF_FFFD);
    finish_run();
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end
endmodule